// File: doc/BRIEF.md
# System Tick Timer

This block is a periodic tick source for a processor subsystem. Software programs a 24-bit reload value and enables the timer. From then on a down-counter steps once per clock. Each time the counter passes from one to zero, the block raises a sticky wrap flag and, if tick interrupts are on, pulses its interrupt line for one cycle. On the following clock it refills itself from the reload value. The period is therefore the reload value plus one clock.

Software reaches the block through four word registers on a plain single-cycle bus:

| Word index (address bits 3:2) | Register |
|---|---|
| 0 | Control |
| 1 | Reload |
| 2 | Current count |
| 3 | Calibration |

Read data is combinational while the read strobe is high. Any side effect of an access takes place at the clock edge that ends that cycle. A debug qualifier on the bus marks a read as non-intrusive, so a debugger can look at the wrap flag without consuming it.

The counter is run by a three-state machine:

- **IDLE**: the timer is disabled and the counter is frozen.
- **COUNT**: the counter is stepping down.
- **WRAP**: the counter has just reached zero and is refilled on the next clock.

Transitions:

- **IDLE→COUNT** (start): a control write turns the enable on. The counter is loaded from the reload value.
- **COUNT→COUNT** (step): the counter decrements. If it holds zero, it is refilled instead.
- **COUNT→WRAP** (wrap): the counter steps from 1 to 0.
- **WRAP→COUNT** (refill): the counter is loaded from the reload value.
- **any→IDLE** (stop): a control write turns the enable off.
- **COUNT or WRAP→COUNT** (zero): a write to the current-count register clears the counter.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word reads 0x4, the reload and current-count registers read 0, the calibration register reads its parameter value, and the interrupt output is low.
- R2: The reload and current-count registers keep only 24 bits. Write data bits 31:24 are dropped, and a read of either register returns 0 in bits 31:24.
- R3: A normal read of the control register returns the wrap flag in bit 16, the clock-source bit in bit 2, the interrupt enable in bit 1 and the enable in bit 0. The wrap flag is cleared at the end of that read.
- R4: A control read with the debug qualifier high returns the same word and leaves the wrap flag unchanged.
- R5: A write to the current-count register clears the counter to 0 whatever the data, with the timer on or off, and does not change the reload value. When the timer is on, the next clock refills the counter from the reload value.
- R6: A control write that turns the enable from 0 to 1 loads the counter from the reload value. A write that turns it from 1 to 0 freezes the counter at its present value.
- R7: A control write sets the enable (bit 0), the interrupt enable (bit 1) and the wrap flag (bit 16) from the write data. Bit 2 (clock source) always reads 1.
- R8: The calibration register is read-only. Writes to it have no effect on its value.
- R9: While enabled, the counter decrements by one per clock. The step from 1 to 0 sets the wrap flag, and the next clock reloads, so with reload value N the count sequence repeats every N+1 clocks.
- R10: The interrupt output is high for exactly the one cycle in which the counter shows 0 after a wrap, and only when the interrupt enable is set.
- R11: With a reload value of 0 the enabled counter stays at 0, and neither the wrap flag nor the interrupt is raised.
- R12: A new reload value written while counting does not disturb the running count. It takes effect at the next refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_dbg | input | 1 | Marks a read as a debug access with no side effect |
| bus_rdata | output | 32 | Read data, combinational while bus_rd is high, otherwise 0 |
| tick_irq | output | 1 | One-cycle tick interrupt request |

## Verification
The bench sweeps reload values 1 through 6, with interrupts both on and off, and checks every cycle of two full periods against an arithmetic model. An off-by-one in the refill would show up there as a period of N or N+2, and an interrupt pulse of the wrong length or phase would be caught as well. It then separates a debug read of the control register from a normal one: a design that clears the flag on every read loses the flag after the debug access, and a design that never clears it keeps the flag after the normal one. Further checks cover these cases:
- a write to the current count while running, where a design that stores the data, or that fails to refill, reads wrong values on the next two cycles;
- a reload of zero, where a design that wraps through all ones, or flags a zero count, raises a spurious tick;
- a reload change in mid-count, where a design that applies the new value at once shortens the running period.

// File: rtl/tt_pkg.sv
package tt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_WRAP  = 2'd2
    } tt_state_e;

    localparam logic [1:0] IDX_CTRL = 2'd0;
    localparam logic [1:0] IDX_RLD  = 2'd1;
    localparam logic [1:0] IDX_CUR  = 2'd2;
    localparam logic [1:0] IDX_CAL  = 2'd3;

    localparam int BIT_EN   = 0;
    localparam int BIT_TINT = 1;
    localparam int BIT_CSRC = 2;
    localparam int BIT_FLAG = 16;

    localparam int BUS_W = 32;

endpackage

// File: rtl/tt_core.sv
module tt_core
    import tt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             zero_req,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_evt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tt_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        wrap_evt = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cnt_d   = reload;
                    state_d = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (cnt_q == ONE) begin
                    cnt_d    = '0;
                    wrap_evt = 1'b1;
                    state_d  = ST_WRAP;
                end else if (cnt_q == '0) begin
                    cnt_d = reload;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            ST_WRAP: begin
                cnt_d   = reload;
                state_d = ST_COUNT;
            end
            default: state_d = ST_IDLE;
        endcase
        if (stop) begin
            state_d  = ST_IDLE;
            cnt_d    = cnt_q;
            wrap_evt = 1'b0;
        end
        if (zero_req) begin
            cnt_d    = '0;
            wrap_evt = 1'b0;
            if (state_d != ST_IDLE) state_d = ST_COUNT;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/tt_regs.sv
module tt_regs
    import tt_pkg::*;
#(
    parameter int          CNT_W     = 24,
    parameter logic [31:0] CAL_VALUE = 32'h0000_2710
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [31:0]      bus_wdata,
    input  logic             bus_rd,
    input  logic             bus_dbg,
    output logic [31:0]      bus_rdata,
    input  logic             wrap_evt,
    input  logic [CNT_W-1:0] cnt,
    output logic             start,
    output logic             stop,
    output logic             zero_req,
    output logic [CNT_W-1:0] reload,
    output logic             en,
    output logic             flag,
    output logic             irq
);

    localparam int PAD_W = BUS_W - CNT_W;

    logic [1:0]       idx;
    logic             ctrl_wr, rld_wr, rd_clr;
    logic             en_q, tint_q, flag_q, irq_q, flag_d;
    logic [CNT_W-1:0] rld_q;
    logic [31:0]      ctrl_word;
    logic             wdata_unused;

    assign idx          = bus_addr[3:2];
    assign wdata_unused = ^{bus_wdata[31:17], bus_wdata[15:2], bus_addr[1:0]};
    assign ctrl_wr      = bus_wr && (idx == IDX_CTRL);
    assign rld_wr       = bus_wr && (idx == IDX_RLD);
    assign zero_req     = bus_wr && (idx == IDX_CUR);
    assign rd_clr       = bus_rd && !bus_dbg && (idx == IDX_CTRL);
    assign start        = ctrl_wr && bus_wdata[BIT_EN] && !en_q;
    assign stop         = ctrl_wr && !bus_wdata[BIT_EN] && en_q;

    always_comb begin
        flag_d = flag_q;
        if (wrap_evt)     flag_d = 1'b1;
        else if (ctrl_wr) flag_d = bus_wdata[BIT_FLAG];
        else if (rd_clr)  flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            tint_q <= 1'b0;
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
            rld_q  <= '0;
        end else begin
            flag_q <= flag_d;
            irq_q  <= wrap_evt && tint_q;
            if (ctrl_wr) begin
                en_q   <= bus_wdata[BIT_EN];
                tint_q <= bus_wdata[BIT_TINT];
            end
            if (rld_wr) rld_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BIT_EN]   = en_q;
        ctrl_word[BIT_TINT] = tint_q;
        ctrl_word[BIT_CSRC] = 1'b1;
        ctrl_word[BIT_FLAG] = flag_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (idx)
                IDX_CTRL: bus_rdata = ctrl_word;
                IDX_RLD:  bus_rdata = {{PAD_W{1'b0}}, rld_q};
                IDX_CUR:  bus_rdata = {{PAD_W{1'b0}}, cnt};
                IDX_CAL:  bus_rdata = CAL_VALUE;
            endcase
        end
    end

    assign reload = rld_q;
    assign en     = en_q;
    assign flag   = flag_q;
    assign irq    = irq_q;

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int          CNT_W     = 24,
    parameter logic [31:0] CAL_VALUE = 32'h0000_2710
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd,
    input  logic        bus_dbg,
    output logic [31:0] bus_rdata,
    output logic        tick_irq
);

    logic             start_w, stop_w, zero_w, wrap_w, en_w, flag_w;
    logic [CNT_W-1:0] rld_w, cnt_w;

    tt_regs #(.CNT_W(CNT_W), .CAL_VALUE(CAL_VALUE)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_dbg(bus_dbg), .bus_rdata(bus_rdata),
        .wrap_evt(wrap_w), .cnt(cnt_w),
        .start(start_w), .stop(stop_w), .zero_req(zero_w),
        .reload(rld_w), .en(en_w), .flag(flag_w), .irq(tick_irq)
    );

    tt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .start(start_w), .stop(stop_w), .zero_req(zero_w),
        .reload(rld_w), .cnt(cnt_w), .wrap_evt(wrap_w)
    );

endmodule

// File: rtl/tt_chk.sv
module tt_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             bus_dbg,
    input logic [31:0]      bus_rdata,
    input logic             tick_irq,
    input logic [CNT_W-1:0] cnt,
    input logic             flag,
    input logic             en,
    input logic             wrap_evt
);

    logic [1:0] idx;
    assign idx = bus_addr[3:2];

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (idx == 2'd1 || idx == 2'd2)) |-> (bus_rdata[31:CNT_W] == '0));

    // R7
    csrc_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && idx == 2'd0) |-> bus_rdata[2]);

    // R3
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_dbg && idx == 2'd0 && !bus_wr && !wrap_evt) |=> !flag);

    // R4
    dbg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_dbg && idx == 2'd0 && !bus_wr && flag) |=> flag);

    // R5
    cur_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == 2'd2) |=> (cnt == '0));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !bus_wr) |=> $stable(cnt));

    // R9
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> flag);

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |=> !tick_irq);

    // R10
    irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |-> (cnt == '0));

endmodule

bind tick_timer tt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_dbg(bus_dbg), .bus_rdata(bus_rdata),
    .tick_irq(tick_irq), .cnt(cnt_w), .flag(flag_w), .en(en_w),
    .wrap_evt(wrap_w)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;

    localparam int          PERIOD = 10;
    localparam logic [31:0] CAL    = 32'h0000_2710;
    localparam logic [3:0]  A_CTRL = 4'h0;
    localparam logic [3:0]  A_RLD  = 4'h4;
    localparam logic [3:0]  A_CUR  = 4'h8;
    localparam logic [3:0]  A_CAL  = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0, dbg = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    tick_timer #(.CNT_W(24), .CAL_VALUE(CAL)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rd(rd), .bus_dbg(dbg),
        .bus_rdata(rdata), .tick_irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_rd(input logic [3:0] a, input logic d, output logic [31:0] q,
                         output logic iq);
        addr = a; dbg = d; rd = 1'b1;
        #1;
        q = rdata; iq = irq;
        @(negedge clk);
        rd = 1'b0; dbg = 1'b0;
    endtask

    initial begin
        #(PERIOD * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        logic        iq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        do_rd(A_CTRL, 1'b1, q, iq); chk("R1 ctrl", q, 32'h4);
        chk("R1 irq", {31'b0, iq}, 32'h0);
        do_rd(A_RLD, 1'b0, q, iq);  chk("R1 reload", q, 32'h0);
        do_rd(A_CUR, 1'b0, q, iq);  chk("R1 current", q, 32'h0);
        do_rd(A_CAL, 1'b0, q, iq);  chk("R1 cal", q, CAL);

        // R9 / R10 sweep over reload values and interrupt enable
        for (int r = 1; r <= 6; r++) begin
            for (int ti = 0; ti < 2; ti++) begin
                do_wr(A_CTRL, 32'h0);
                do_wr(A_RLD, 32'(r));
                do_wr(A_CTRL, (ti == 1) ? 32'h3 : 32'h1);
                for (int k = 0; k < 2 * (r + 1); k++) begin
                    int e;
                    e = r - (k % (r + 1));
                    do_rd(A_CUR, 1'b0, q, iq);
                    chk("R9 count", q, 32'(e));
                    chk("R10 irq", {31'b0, iq}, {31'b0, (ti == 1 && e == 0)});
                end
                do_rd(A_CTRL, 1'b1, q, iq);
                chk("R9 flag", {31'b0, q[16]}, 32'h1);
            end
        end

        // R3 / R4 read side effects on the flag
        do_wr(A_CTRL, 32'h0001_0000);
        do_rd(A_CTRL, 1'b1, q, iq); chk("R4 dbg read 1", q, 32'h0001_0004);
        do_rd(A_CTRL, 1'b1, q, iq); chk("R4 dbg read 2", q, 32'h0001_0004);
        do_rd(A_CTRL, 1'b0, q, iq); chk("R3 normal read", q, 32'h0001_0004);
        do_rd(A_CTRL, 1'b0, q, iq); chk("R3 flag cleared", q, 32'h4);

        // R6 enable load and disable freeze
        do_wr(A_RLD, 32'd9);
        do_wr(A_CTRL, 32'h1);
        do_rd(A_CUR, 1'b0, q, iq); chk("R6 load", q, 32'd9);
        do_rd(A_CUR, 1'b0, q, iq); chk("R6 step", q, 32'd8);
        do_wr(A_CTRL, 32'h0);
        do_rd(A_CUR, 1'b0, q, iq); chk("R6 frozen 1", q, 32'd7);
        do_rd(A_CUR, 1'b0, q, iq); chk("R6 frozen 2", q, 32'd7);

        // R5 current write while disabled, then while running
        do_wr(A_CUR, 32'hFFFF_FFFF);
        do_rd(A_CUR, 1'b0, q, iq); chk("R5 zero idle", q, 32'h0);
        do_rd(A_RLD, 1'b0, q, iq); chk("R5 reload kept", q, 32'd9);
        do_wr(A_RLD, 32'd5);
        do_wr(A_CTRL, 32'h1);
        do_rd(A_CUR, 1'b0, q, iq); chk("R5 start", q, 32'd5);
        do_wr(A_CUR, 32'h00AB_CDEF);
        do_rd(A_CUR, 1'b0, q, iq); chk("R5 zero run", q, 32'h0);
        do_rd(A_CUR, 1'b0, q, iq); chk("R5 refill", q, 32'd5);
        do_rd(A_CUR, 1'b0, q, iq); chk("R5 resume", q, 32'd4);
        do_rd(A_CTRL, 1'b1, q, iq); chk("R5 no flag", q, 32'h5);

        // R2 24-bit registers
        do_wr(A_CTRL, 32'h0);
        do_wr(A_RLD, 32'hFF00_0007);
        do_rd(A_RLD, 1'b0, q, iq); chk("R2 reload trunc", q, 32'h7);

        // R7 control write fields
        do_wr(A_CTRL, 32'h3);
        do_rd(A_CTRL, 1'b1, q, iq); chk("R7 set en tint", q, 32'h7);
        do_wr(A_CTRL, 32'hFFFF_FFFF);
        do_rd(A_CTRL, 1'b1, q, iq); chk("R7 set flag", q, 32'h0001_0007);
        do_wr(A_CTRL, 32'h0);
        do_rd(A_CTRL, 1'b1, q, iq); chk("R7 csrc stuck", q, 32'h4);

        // R8 calibration read-only
        do_wr(A_CAL, 32'h1234_5678);
        do_rd(A_CAL, 1'b0, q, iq); chk("R8 cal", q, CAL);

        // R11 reload of zero
        do_wr(A_RLD, 32'h0);
        do_wr(A_CTRL, 32'h3);
        for (int k = 0; k < 6; k++) begin
            do_rd(A_CUR, 1'b0, q, iq); chk("R11 stays zero", q, 32'h0);
            chk("R11 no irq", {31'b0, iq}, 32'h0);
        end
        do_rd(A_CTRL, 1'b1, q, iq); chk("R11 no flag", q, 32'h7);

        // R12 reload change mid-count
        do_wr(A_CTRL, 32'h0);
        do_wr(A_RLD, 32'd10);
        do_wr(A_CTRL, 32'h1);
        do_wr(A_RLD, 32'd3);
        for (int k = 1; k <= 12; k++) begin
            int e;
            e = (k <= 10) ? (10 - k) : ((k == 11) ? 3 : 2);
            do_rd(A_CUR, 1'b0, q, iq);
            chk("R12 count", q, 32'(e));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule